// File: doc/BRIEF.md
# Capture/Compare Event Unit

This unit pairs one shared data register with a free-running timer value supplied from outside. A 4-bit mode field decides what the register is for. In the capture modes the unit stores the timer value when the external input shows a selected edge. The input can be taken on each falling edge, on each rising edge, or only on every 4th or 16th rising edge. In the compare modes the unit watches for the timer to reach the register value. When it does, it toggles or forces its output pin, only raises the interrupt flag, or asks for a timer reset together with a converter-start pulse.

Software writes the mode field and the register through simple write strobes and reads the register back on `cap_data`. The interrupt flag stays set until software clears it. The external input is raw and asynchronous, so the unit synchronizes it before looking for edges. When `cmp_own` is low, pin-level logic outside the unit decides the pin, and the unit only reports through the flag and strobes.

Top module: `capcmp_unit`

## Requirements
- R1: A synchronous active-high reset clears the mode field to 0000, `cap_data`, `cmp_pin`, `cmp_own`, `irq_flag`, `tmr_rst_req` and `adc_start`.
- R2: Mode codes 0000, 0001, 0011 and 11xx disable the unit. Writing one of them drives `cmp_pin` to 0 and `cmp_own` to 0 and clears the edge prescale count. While disabled, nothing is captured, the flag is never set, and no strobe fires.
- R3: Mode 0100 captures on each falling edge of `pin_in` and mode 0101 on each rising edge. A capture loads `tmr_val` into the register and sets `irq_flag`. The sampled `tmr_val` is the one present at the third rising clock edge after `pin_in` changes, counting the first edge that sees the new level as the first. The new value shows on `cap_data` after that edge.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge, counted from the last write of the mode field.
- R5: Mode 0010 toggles `cmp_pin` at each compare match and sets `irq_flag`. `cmp_own` is 1 in this mode.
- R6: Writing mode 1000 drives `cmp_pin` to 0, and a match then forces it to 1. Writing mode 1001 drives it to 1, and a match forces it to 0. Both modes set `irq_flag` on a match and hold `cmp_own` at 1.
- R7: Mode 1010 sets `irq_flag` on a match and never changes `cmp_pin`. `cmp_own` is 0 in this mode.
- R8: In mode 1011 a match sets `irq_flag` and pulses `tmr_rst_req` and `adc_start` high together for exactly one cycle, on the edge where the match is taken. No other mode raises these strobes.
- R9: A match is taken on the first clock edge where `tmr_val` equals the register. A timer held at that value produces no further match until the two differ and become equal again.
- R10: `irq_flag` stays set until `flag_clr` is pulsed. If a match or capture happens in the same cycle as `flag_clr`, the flag is set.
- R11: `reg_we` loads `reg_wdata` into the register, and `cap_data` shows it after the next edge. A software write takes priority over a capture in the same cycle.
- R12: Every mode-field write restarts the edge prescale count, including a rewrite of the same mode. Rising edges counted before the write do not contribute to the next capture. In the cycle of a mode-field write, no capture or match is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | New mode code |
| reg_we | input | 1 | Write strobe for the data register |
| reg_wdata | input | TW | Value written to the data register |
| flag_clr | input | 1 | Clears the interrupt flag |
| tmr_val | input | TW | Current value of the external timer |
| pin_in | input | 1 | Raw asynchronous capture input |
| cap_data | output | TW | Data register read-back |
| cmp_pin | output | 1 | Output latch driven by compare modes |
| cmp_own | output | 1 | 1 when the unit owns the output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_rst_req | output | 1 | One-cycle timer reset request |
| adc_start | output | 1 | One-cycle converter-start strobe |

## Verification
The bench targets the following corner cases and the fault each one exposes:
- A timer parked on the register value must count as one match. A design that matches on level instead of onset would keep toggling the pin or keep re-firing the strobes.
- Rewriting the same prescaled capture mode partway through a count must discard the partial count. A design that keeps the old count would capture one edge early.
- A software write arriving in the same cycle as a capture must win. A design that got this priority backwards would show the timer value.
- A flag clear arriving together with a match must leave the flag set. A design that got this priority backwards would lose the interrupt.
- Random mode changes, including the reserved and upper codes, are compared cycle by cycle against a bench model. The model catches wrong entry levels, captures taken on the wrong edge, and captures off by one cycle through the synchronizer.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  localparam int MODE_W = 4;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MD_OFF         = 4'b0000;
  localparam mode_t MD_TOGGLE      = 4'b0010;
  localparam mode_t MD_CAP_FALL    = 4'b0100;
  localparam mode_t MD_CAP_RISE    = 4'b0101;
  localparam mode_t MD_CAP_RISE4   = 4'b0110;
  localparam mode_t MD_CAP_RISE16  = 4'b0111;
  localparam mode_t MD_HIGH_ON_HIT = 4'b1000;
  localparam mode_t MD_LOW_ON_HIT  = 4'b1001;
  localparam mode_t MD_FLAG_ONLY   = 4'b1010;
  localparam mode_t MD_TRIGGER     = 4'b1011;

  // compare family: toggle code plus the whole 10xx group
  function automatic logic is_compare(input mode_t m);
    return (m == MD_TOGGLE) || (m[3:2] == 2'b10);
  endfunction

  // capture family: the whole 01xx group
  function automatic logic is_capture(input mode_t m);
    return (m[3:2] == 2'b01);
  endfunction

  // everything else (reserved and upper codes) behaves as disabled
  function automatic logic is_idle(input mode_t m);
    return !is_compare(m) && !is_capture(m);
  endfunction

  function automatic logic is_prescaled(input mode_t m);
    return (m == MD_CAP_RISE4) || (m == MD_CAP_RISE16);
  endfunction

  function automatic logic owns_pin(input mode_t m);
    return (m == MD_TOGGLE) || (m == MD_HIGH_ON_HIT) || (m == MD_LOW_ON_HIT);
  endfunction

endpackage

// File: rtl/capcmp_sync.sv
// Multi-stage synchronizer for the raw input followed by an edge detector.
module capcmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= pin_in;
  end

  // remaining synchronizer stages plus one history stage
  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign rise =  chain[LAST-1] & ~chain[LAST];
  assign fall = ~chain[LAST-1] &  chain[LAST];
endmodule

// File: rtl/capcmp_prescale.sv
// Counts qualifying edges; fire marks the edge that completes a group.
module capcmp_prescale #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          edge_in,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt;

  assign fire = edge_in && !clear && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (edge_in)  cnt <= fire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/capcmp_match.sv
// Equality detector that reports only the onset of a match.
module capcmp_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          enable,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] ref_val,
  output logic          onset
);
  logic eq_now, eq_q;

  assign eq_now = enable && (tmr == ref_val);
  assign onset  = eq_now && !eq_q && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) eq_q <= 1'b0;
    else              eq_q <= eq_now;
  end
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
  import capcmp_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PSC_W       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  logic [3:0]    mode_wdata,
  input  logic          reg_we,
  input  logic [TW-1:0] reg_wdata,
  input  logic          flag_clr,
  input  logic [TW-1:0] tmr_val,
  input  logic          pin_in,
  output logic [TW-1:0] cap_data,
  output logic          cmp_pin,
  output logic          cmp_own,
  output logic          irq_flag,
  output logic          tmr_rst_req,
  output logic          adc_start
);
  localparam logic [PSC_W-1:0] LIM_4  = PSC_W'(3);
  localparam logic [PSC_W-1:0] LIM_16 = PSC_W'(15);

  mode_t         mode_q;
  logic [TW-1:0] reg_q;
  logic          own_q, pin_q, flag_q, trst_q, conv_q;

  // ---- input edges
  logic rise, fall;
  capcmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rise(rise), .fall(fall)
  );

  // ---- edge prescaler (restarts on any mode write or outside its modes)
  logic             psc_clear, psc_fire;
  logic [PSC_W-1:0] psc_lim;
  assign psc_clear = mode_we || !is_prescaled(mode_q);
  assign psc_lim   = (mode_q == MD_CAP_RISE16) ? LIM_16 : LIM_4;

  capcmp_prescale #(.CW(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .clear(psc_clear), .edge_in(rise),
    .limit(psc_lim), .fire(psc_fire)
  );

  // ---- compare onset
  logic hit, cmp_en;
  assign cmp_en = is_compare(mode_q);

  capcmp_match #(.TW(TW)) u_match (
    .clk(clk), .rst(rst), .clear(mode_we), .enable(cmp_en),
    .tmr(tmr_val), .ref_val(reg_q), .onset(hit)
  );

  // ---- capture event selection
  logic cap_ev;
  always_comb begin
    cap_ev = 1'b0;
    if (!mode_we) begin
      unique case (mode_q)
        MD_CAP_FALL:                 cap_ev = fall;
        MD_CAP_RISE:                 cap_ev = rise;
        MD_CAP_RISE4, MD_CAP_RISE16: cap_ev = psc_fire;
        default:                     cap_ev = 1'b0;
      endcase
    end
  end

  // ---- mode field, ownership and output latch
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_OFF;
      own_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else if (mode_we) begin
      mode_q <= mode_wdata;
      own_q  <= owns_pin(mode_wdata);
      if (mode_wdata == MD_LOW_ON_HIT)
        pin_q <= 1'b1;
      else if (mode_wdata == MD_HIGH_ON_HIT || is_idle(mode_wdata))
        pin_q <= 1'b0;
    end else if (hit) begin
      unique case (mode_q)
        MD_TOGGLE:      pin_q <= ~pin_q;
        MD_HIGH_ON_HIT: pin_q <= 1'b1;
        MD_LOW_ON_HIT:  pin_q <= 1'b0;
        default:        pin_q <= pin_q;
      endcase
    end
  end

  // ---- special-event strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      trst_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      trst_q <= hit && (mode_q == MD_TRIGGER);
      conv_q <= hit && (mode_q == MD_TRIGGER);
    end
  end

  // ---- shared data register: software write beats capture
  always_ff @(posedge clk) begin
    if (rst)         reg_q <= '0;
    else if (reg_we) reg_q <= reg_wdata;
    else if (cap_ev) reg_q <= tmr_val;
  end

  // ---- sticky flag: set beats clear
  always_ff @(posedge clk) begin
    if (rst)                flag_q <= 1'b0;
    else if (hit || cap_ev) flag_q <= 1'b1;
    else if (flag_clr)      flag_q <= 1'b0;
  end

  assign cap_data    = reg_q;
  assign cmp_pin     = pin_q;
  assign cmp_own     = own_q;
  assign irq_flag    = flag_q;
  assign tmr_rst_req = trst_q;
  assign adc_start   = conv_q;
endmodule

// File: rtl/capcmp_unit_chk.sv
module capcmp_unit_chk
  import capcmp_pkg::*;
#(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    mode_q,
  input logic          mode_we,
  input logic          reg_we,
  input logic [TW-1:0] reg_wdata,
  input logic          flag_clr,
  input logic [TW-1:0] cap_data,
  input logic          cmp_pin,
  input logic          irq_flag,
  input logic          tmr_rst_req,
  input logic          adc_start
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    is_idle(mode_q) |-> (!cmp_pin && !tmr_rst_req && !adc_start));

  // R7
  flag_only_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_FLAG_ONLY && !mode_we) |=> $stable(cmp_pin));

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_rst_req |=> !tmr_rst_req);

  // R8
  strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (tmr_rst_req || adc_start) |-> (mode_q == MD_TRIGGER));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag);

  // R11
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (cap_data == $past(reg_wdata)));
endmodule

bind capcmp_unit capcmp_unit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .mode_we(mode_we),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .flag_clr(flag_clr),
  .cap_data(cap_data), .cmp_pin(cmp_pin), .irq_flag(irq_flag),
  .tmr_rst_req(tmr_rst_req), .adc_start(adc_start)
);

// File: tb/capcmp_unit_test.sv
`timescale 1ns/1ps
module capcmp_unit_test;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst = 1'b1;
  logic          mode_we = 1'b0;
  logic [3:0]    mode_wdata = '0;
  logic          reg_we = 1'b0;
  logic [TW-1:0] reg_wdata = '0;
  logic          flag_clr = 1'b0;
  logic [TW-1:0] tmr_val = '0;
  logic          pin_in = 1'b0;
  logic [TW-1:0] cap_data;
  logic          cmp_pin, cmp_own, irq_flag, tmr_rst_req, adc_start;

  capcmp_unit #(.TW(TW)) uut (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .flag_clr(flag_clr),
    .tmr_val(tmr_val), .pin_in(pin_in), .cap_data(cap_data),
    .cmp_pin(cmp_pin), .cmp_own(cmp_own), .irq_flag(irq_flag),
    .tmr_rst_req(tmr_rst_req), .adc_start(adc_start)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model, written from the requirements
  function automatic bit mdl_cmp(input logic [3:0] m);
    return (m == 4'b0010) || (m[3:2] == 2'b10);
  endfunction
  function automatic bit mdl_off(input logic [3:0] m);
    return !mdl_cmp(m) && (m[3:2] != 2'b01);
  endfunction
  function automatic string tag_of(input logic [3:0] m);
    if (mdl_off(m))                return "R2";
    if (m == 4'b0100 || m == 4'b0101) return "R3";
    if (m == 4'b0110 || m == 4'b0111) return "R4";
    if (m == 4'b0010)              return "R5";
    if (m == 4'b1000 || m == 4'b1001) return "R6";
    if (m == 4'b1010)              return "R7";
    return "R8";
  endfunction

  logic [3:0]    m_mode;
  logic [TW-1:0] m_reg;
  logic          m_pin, m_own, m_flag, m_trst, m_conv, m_eq;
  logic          p1, p2, p3;
  int            m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_reg = 0; m_pin = 0; m_own = 0; m_flag = 0;
      m_trst = 0; m_conv = 0; m_eq = 0; m_cnt = 0;
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      logic r_e, f_e, cap, ev, eq;
      r_e = p2 & ~p3;
      f_e = ~p2 & p3;
      p3 = p2; p2 = p1; p1 = pin_in;
      cap = 0; ev = 0; m_trst = 0; m_conv = 0;
      if (mode_we) begin
        m_mode = mode_wdata; m_cnt = 0; m_eq = 0;
        m_own = (mode_wdata == 4'b0010 || mode_wdata == 4'b1000 || mode_wdata == 4'b1001);
        if (mode_wdata == 4'b1001) m_pin = 1;
        else if (mode_wdata == 4'b1000 || mdl_off(mode_wdata)) m_pin = 0;
      end else begin
        if (m_mode == 4'b0100 && f_e) cap = 1;
        if (m_mode == 4'b0101 && r_e) cap = 1;
        if (m_mode == 4'b0110 || m_mode == 4'b0111) begin
          if (r_e) begin
            if (m_cnt == ((m_mode == 4'b0110) ? 3 : 15)) begin cap = 1; m_cnt = 0; end
            else m_cnt++;
          end
        end else m_cnt = 0;
        eq = mdl_cmp(m_mode) && (tmr_val == m_reg);
        ev = eq && !m_eq;
        m_eq = eq;
        if (ev) begin
          if (m_mode == 4'b0010) m_pin = ~m_pin;
          if (m_mode == 4'b1000) m_pin = 1;
          if (m_mode == 4'b1001) m_pin = 0;
          if (m_mode == 4'b1011) begin m_trst = 1; m_conv = 1; end
        end
      end
      if (reg_we) m_reg = reg_wdata;
      else if (cap) m_reg = tmr_val;
      if (ev || cap) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst && !done)
      chk(tag_of(m_mode),
          {11'd0, cap_data, cmp_pin, cmp_own, irq_flag, tmr_rst_req, adc_start},
          {11'd0, m_reg, m_pin, m_own, m_flag, m_trst, m_conv});
  end

  // ---------------- stimulus helpers
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    mode_we = 0; reg_we = 0; flag_clr = 0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_we = 1; mode_wdata = m; cyc(); mode_we = 0;
  endtask

  task automatic pulse();
    pin_in = 1; cyc(); cyc(); pin_in = 0; cyc(); cyc();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) cyc();
    // R1: reset state, still in reset
    chk("R1", {11'd0, cap_data, cmp_pin, cmp_own, irq_flag, tmr_rst_req, adc_start}, 32'd0);
    rst = 0;
    cmp_on = 1;
    cyc();

    // ---------------- constrained random phases
    for (int ph = 0; ph < 24; ph++) begin
      set_mode(4'($urandom_range(0, 15)));
      for (int k = 0; k < 400; k++) begin
        reg_we   = ($urandom_range(0, 39) == 0);
        reg_wdata = 16'($urandom_range(0, 47));
        flag_clr = ($urandom_range(0, 29) == 0);
        if ($urandom_range(0, 4) == 0) pin_in = ~pin_in;
        if ($urandom_range(0, 9) != 0) tmr_val = (tmr_val >= 16'd47) ? 16'd0 : tmr_val + 16'd1;
        cyc();
      end
      idle();
    end

    // ---------------- R9 / R5: onset-only match with parked timer
    mode_we = 1; mode_wdata = 4'b0000; reg_we = 1; reg_wdata = 16'd100;
    tmr_val = 16'd5; flag_clr = 1; cyc(); idle();
    set_mode(4'b0010);
    tmr_val = 16'd100;
    repeat (5) cyc();
    chk("R9 pin after parked match", cmp_pin, 1);
    chk("R9 flag after parked match", irq_flag, 1);
    tmr_val = 16'd101; cyc();
    tmr_val = 16'd100; cyc();
    chk("R5 second toggle", cmp_pin, 0);

    // ---------------- R10: sticky flag, clear, and set-beats-clear
    flag_clr = 1; tmr_val = 16'd101; cyc(); flag_clr = 0;
    chk("R10 cleared", irq_flag, 0);
    cyc();
    chk("R10 stays clear", irq_flag, 0);
    tmr_val = 16'd100; flag_clr = 1; cyc(); flag_clr = 0;
    chk("R10 set wins over clear", irq_flag, 1);

    // ---------------- R8: special event strobes
    tmr_val = 16'd101;
    set_mode(4'b1011);
    tmr_val = 16'd100; cyc();
    chk("R8 strobes high", {tmr_rst_req, adc_start}, 2'b11);
    cyc();
    chk("R8 strobes one cycle", {tmr_rst_req, adc_start}, 2'b00);

    // ---------------- R6 / R2: entry levels
    tmr_val = 16'd101;
    set_mode(4'b1001);
    chk("R6 entry high", {cmp_pin, cmp_own}, 2'b11);
    tmr_val = 16'd100; cyc();
    chk("R6 forced low on match", cmp_pin, 0);
    set_mode(4'b1000);
    chk("R6 entry low", {cmp_pin, cmp_own}, 2'b01);
    tmr_val = 16'd101; cyc(); tmr_val = 16'd100; cyc();
    chk("R6 forced high on match", cmp_pin, 1);
    set_mode(4'b0011);
    chk("R2 reserved code idles pin", {cmp_pin, cmp_own}, 2'b00);

    // ---------------- R11 / R3: write beats capture; rising capture latency
    pin_in = 0;
    set_mode(4'b0101);
    repeat (3) cyc();
    pin_in = 1; tmr_val = 16'd700; cyc(); cyc();
    reg_we = 1; reg_wdata = 16'd1234; tmr_val = 16'd777; cyc(); reg_we = 0;
    chk("R11 write beats capture", cap_data, 16'd1234);
    pin_in = 0; repeat (3) cyc();
    pin_in = 1; tmr_val = 16'd555; cyc(); cyc();
    tmr_val = 16'd556; cyc();
    chk("R3 capture on third edge", cap_data, 16'd556);
    pin_in = 0; repeat (3) cyc();

    // ---------------- R12 / R4: rewrite restarts the prescale count
    tmr_val = 16'd900;
    set_mode(4'b0110);
    repeat (3) pulse();
    set_mode(4'b0110);
    repeat (3) pulse();
    chk("R12 partial count discarded", cap_data, 16'd556);
    tmr_val = 16'd901;
    pulse();
    chk("R4 fourth rise captures", cap_data, 16'd901);

    repeat (4) cyc();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule